// File: doc/BRIEF.md
# Sensor Read Frame CRC-8 Checker

This block validates the check byte that a thermal sensor appends to a frame it returns over I2C. Bytes arrive as a stream with a valid strobe and a separate start strobe. The checker runs a CRC-8 over the bus header bytes that the sensor also folds into its own code, then over the payload. It compares the result with the final byte of the frame.

The bus header is not on the data stream. The block injects it itself, and a mode input picks which header applies. With a repeated start, the write address, the command and the read address are all covered. With a stop followed by a fresh start, only the read address is covered. A length input picks the short or the long frame. At the end of the frame the block gives a one-cycle done strobe, a pass flag and the CRC value it computed, so that the bus master can drop a bad read and retry it.

Top module: `pec_frame_checker`

## Requirements
- R1: The CRC is CRC-8 with polynomial 0x07 and a zero start value. Each byte is XORed into the register, and then eight steps shift it left, MSB first, applying XOR 0x07 whenever the bit shifted out is 1.
- R2: With `hdr_rs`=1 (repeated start), the bytes 0x14, 0x4C and 0x15 are absorbed in that order before the payload. The 34-byte reference payload 34 01 18 01 1A 01 1E 01 21 01 11 01 15 01 0D 01 10 01 08 01 FD 00 FA 00 FD 00 06 01 F7 00 F8 00 FA 00 then yields 0x9E.
- R3: With `hdr_rs`=0 (stop then start), only 0x15 is absorbed before the payload, and the same reference payload yields 0xAF.
- R4: With `len_long`=0 the frame is 11 bytes; with `len_long`=1 it is 35 bytes. The CRC covers every byte but the last. Mode and length are captured on the start strobe.
- R5: On the last byte, `frame_ok` is 1 exactly when the computed CRC equals that byte, and `crc_value` shows the computed CRC.
- R6: `in_ready` is low in the start cycle and for 3 cycles after it with `hdr_rs`=1, or 1 cycle after it with `hdr_rs`=0. It then goes high.
- R7: Bytes offered with `in_valid` while `in_ready` is low, both during header injection and after a frame has finished, have no effect on the CRC, the outputs or the byte count.
- R8: A start strobe aborts any frame in progress. It clears the CRC register and the byte count, and the strobe cycle's data is not taken.
- R9: `frame_done` is a one-cycle pulse. `frame_ok` and `crc_value` are 0 after reset, are cleared by a start strobe, and are otherwise held from done until the next start.
- R10: Once `in_ready` is high, one byte is accepted on every cycle in which `in_valid` is high, so a gapless frame of N bytes finishes N cycles after `in_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sof | input | 1 | Start of frame strobe; carries no data |
| in_valid | input | 1 | Data byte valid |
| in_data | input | 8 | Received byte |
| hdr_rs | input | 1 | 1: repeated-start header, 0: stop/start header |
| len_long | input | 1 | 1: 35-byte frame, 0: 11-byte frame |
| in_ready | output | 1 | Byte is accepted when high together with in_valid |
| frame_done | output | 1 | One-cycle pulse after the check byte is taken |
| frame_ok | output | 1 | Check byte matched the computed CRC |
| crc_value | output | 8 | CRC computed over header and covered bytes |

## Verification
The assertions assume that the start strobe is the only thing that begins a frame. They also assume that a byte counts only when valid and ready are both high, so the one-pulse and hold properties are exempt only in start and final-byte cycles. The stimulus keeps to this by driving all inputs at the falling edge and holding each byte until ready has been seen high. It also offers junk bytes with valid high during header injection and after completion, to show that they are dropped. Mode and length are changed only together with a start strobe, and a few frames are cut off by a new start to exercise the abort path.

// File: rtl/pec_pkg.sv
// Package: shared constants and types for the frame CRC checker.
// Assumes 8-bit bytes and the two frame sizes of the sensor family.
package pec_pkg;
    localparam int BYTE_W    = 8;
    localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;
    localparam int LEN_SHORT = 11;
    localparam int LEN_LONG  = 35;
    localparam int CNT_W     = $clog2(LEN_LONG);
    localparam int RS_HDR_N  = 3;
    localparam int SS_HDR_N  = 1;
    localparam int HDR_MAX   = RS_HDR_N;
    localparam int IDX_W     = $clog2(HDR_MAX);
    // repeated-start header, entry 0 is absorbed first
    localparam logic [RS_HDR_N-1:0][BYTE_W-1:0] RS_HDR = {8'h15, 8'h4C, 8'h14};
    // stop/start header: read address only
    localparam logic [SS_HDR_N-1:0][BYTE_W-1:0] SS_HDR = {8'h15};

    typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY} pec_state_e;
endpackage

// File: rtl/pec_crc_unit.sv
// CRC-8 register with a byte-wide update unrolled into W shift stages.
// Assumes clr has priority over en; one byte absorbed per enabled cycle.
module pec_crc_unit #(
    parameter int W = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] crc_q
);
    logic [W-1:0] stage [W+1];

    // fold the byte into the register before shifting
    always_comb stage[0] = crc_q ^ din;

    generate
        for (genvar k = 0; k < W; k++) begin : g_step
            // one MSB-first shift with conditional polynomial XOR
            assign stage[k+1] = stage[k][W-1] ? ({stage[k][W-2:0], 1'b0} ^ POLY)
                                              : {stage[k][W-2:0], 1'b0};
        end
    endgenerate

    // register update: clear on new frame, absorb when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= '0;
        else if (clr)  crc_q <= '0;
        else if (en)   crc_q <= stage[W];
    end

    // R8
    clear_on_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == '0));
endmodule

// File: rtl/pec_hdr_sel.sv
// Header byte selector: gives the implicit bus header byte at an index
// and flags the last one for the chosen transaction style.
module pec_hdr_sel
    import pec_pkg::*;
(
    input  logic              mode_rs,
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] hdr_byte,
    output logic              hdr_last
);
    // pick the header byte for the active style
    always_comb begin
        hdr_byte = SS_HDR[0];
        if (mode_rs) begin
            for (int i = 0; i < RS_HDR_N; i++)
                if (idx == IDX_W'(i)) hdr_byte = RS_HDR[i];
        end
    end

    // last header index for the active style
    always_comb hdr_last = mode_rs ? (idx == IDX_W'(RS_HDR_N - 1))
                                   : (idx == IDX_W'(SS_HDR_N - 1));
endmodule

// File: rtl/pec_frame_ctrl.sv
// Frame sequencer: captures mode/length on start, walks the header,
// then counts covered bytes and marks the check byte.
// Assumes in_sof carries no data and overrides everything.
module pec_frame_ctrl
    import pec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             valid,
    input  logic             mode_rs,
    input  logic             len_long,
    input  logic             hdr_last,
    output logic             ready,
    output logic             hdr_active,
    output logic             data_take,
    output logic             pec_take,
    output logic             mode_q,
    output logic [IDX_W-1:0] hdr_idx
);
    localparam logic [CNT_W-1:0] PEC_SHORT = CNT_W'(LEN_SHORT - 1);
    localparam logic [CNT_W-1:0] PEC_LONG  = CNT_W'(LEN_LONG - 1);

    pec_state_e       state;
    logic             len_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] pec_idx;
    logic             acc;

    // handshake and byte classification
    always_comb begin
        pec_idx    = len_q ? PEC_LONG : PEC_SHORT;
        ready      = (state == ST_PAY) && !sof;
        hdr_active = (state == ST_HDR) && !sof;
        acc        = ready && valid;
        pec_take   = acc && (cnt == pec_idx);
        data_take  = acc && (cnt != pec_idx);
    end

    // state, header index and byte counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode_q  <= 1'b0;
            len_q   <= 1'b0;
            cnt     <= '0;
            hdr_idx <= '0;
        end else if (sof) begin
            state   <= ST_HDR;
            mode_q  <= mode_rs;
            len_q   <= len_long;
            cnt     <= '0;
            hdr_idx <= '0;
        end else begin
            case (state)
                ST_HDR: begin
                    if (hdr_last) state <= ST_PAY;
                    else          hdr_idx <= hdr_idx + 1'b1;
                end
                ST_PAY: begin
                    if (pec_take)       state <= ST_IDLE;
                    else if (data_take) cnt <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAY) |-> (cnt <= pec_idx));
    // R8
    sof_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (cnt == '0 && state == ST_HDR));
endmodule

// File: rtl/pec_frame_checker.sv
// Top: CRC-8 check of a sensor read frame with injected bus header.
// Assumes the bus master presents bytes in order and strobes in_sof
// once per read; results stay valid until the next in_sof.
module pec_frame_checker
    import pec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sof,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              hdr_rs,
    input  logic              len_long,
    output logic              in_ready,
    output logic              frame_done,
    output logic              frame_ok,
    output logic [BYTE_W-1:0] crc_value
);
    logic              hdr_active, data_take, pec_take, mode_q, hdr_last;
    logic [IDX_W-1:0]  hdr_idx;
    logic [BYTE_W-1:0] hdr_byte, crc_din, crc_q;

    pec_frame_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sof(in_sof), .valid(in_valid),
        .mode_rs(hdr_rs), .len_long(len_long), .hdr_last(hdr_last),
        .ready(in_ready), .hdr_active(hdr_active), .data_take(data_take),
        .pec_take(pec_take), .mode_q(mode_q), .hdr_idx(hdr_idx)
    );

    pec_hdr_sel u_hdr (
        .mode_rs(mode_q), .idx(hdr_idx), .hdr_byte(hdr_byte), .hdr_last(hdr_last)
    );

    // feed header bytes while injecting, stream bytes otherwise
    always_comb crc_din = hdr_active ? hdr_byte : in_data;

    pec_crc_unit #(.W(BYTE_W), .POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(in_sof),
        .en(hdr_active || data_take), .din(crc_din), .crc_q(crc_q)
    );

    // result registers: clear on start, capture on check byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            frame_ok   <= 1'b0;
            crc_value  <= '0;
        end else if (in_sof) begin
            frame_done <= 1'b0;
            frame_ok   <= 1'b0;
            crc_value  <= '0;
        end else begin
            frame_done <= pec_take;
            if (pec_take) begin
                frame_ok  <= (crc_q == in_data);
                crc_value <= crc_q;
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sof && !pec_take) |=> ($stable(crc_value) && $stable(frame_ok)));
    // R5
    ok_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pec_take |=> (frame_ok == (crc_value == $past(in_data))));
    // R6
    sof_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_sof |=> !in_ready);
endmodule

// File: tb/pec_frame_checker_tb.sv
module pec_frame_checker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_sof = 1'b0, in_valid = 1'b0, hdr_rs = 1'b0, len_long = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, frame_done, frame_ok;
    logic [7:0] crc_value;
    int n_chk = 0, n_fail = 0, cyc = 0, npass = 0;
    logic [7:0] refpl [34] = '{8'h34,8'h01,8'h18,8'h01,8'h1a,8'h01,8'h1e,8'h01,8'h21,8'h01,
                               8'h11,8'h01,8'h15,8'h01,8'h0d,8'h01,8'h10,8'h01,8'h08,8'h01,
                               8'hfd,8'h00,8'hfa,8'h00,8'hfd,8'h00,8'h06,8'h01,8'hf7,8'h00,
                               8'hf8,8'h00,8'hfa,8'h00};

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pec_frame_checker dut_i (
        .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .in_valid(in_valid),
        .in_data(in_data), .hdr_rs(hdr_rs), .len_long(len_long),
        .in_ready(in_ready), .frame_done(frame_done), .frame_ok(frame_ok),
        .crc_value(crc_value)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R1 bench model: bitwise CRC-8, poly 0x07, MSB first
    function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c ^ b;
        for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    function automatic logic [7:0] pl_byte(input int pat, input int i);
        if (pat == 0) return refpl[i];
        return 8'((i * 37 + pat * 11 + 5) ^ (pat << 4));
    endfunction

    task automatic push(input logic [7:0] d);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic start_frame(input bit rs, input bit lng);
        @(negedge clk);
        in_sof = 1'b1; in_valid = 1'b1; in_data = 8'hC3; hdr_rs = rs; len_long = lng;
        @(negedge clk);
        in_sof = 1'b0;
    endtask

    // full frame; returns expected CRC through exp_o
    task automatic run_frame(input bit rs, input bit lng, input int pat, input bit gap,
                             input bit force_pec, input logic [7:0] pec_in,
                             input bit corrupt, output logic [7:0] exp_o);
        int L = lng ? 35 : 11;
        int n = 0;
        int t0;
        logic [7:0] e = 8'h00;
        logic [7:0] pec;
        logic [7:0] held_crc;
        logic held_ok;
        start_frame(rs, lng);
        chk(crc_value == 0 && frame_ok == 0 && frame_done == 0, "R9 clear on start", crc_value, 0);
        in_valid = 1'b1; in_data = 8'hEE;   // R7 junk offered during header
        while (!in_ready) begin n++; @(negedge clk); end
        chk(n == (rs ? 3 : 1), "R6 header ready-low cycles", n, rs ? 3 : 1);
        if (rs) begin e = crc_byte(e, 8'h14); e = crc_byte(e, 8'h4C); end
        e = crc_byte(e, 8'h15);
        t0 = cyc;
        for (int i = 0; i < L - 1; i++) begin
            e = crc_byte(e, pl_byte(pat, i));
            push(pl_byte(pat, i));
            if (gap) begin in_valid = 1'b0; @(negedge clk); end
        end
        chk(frame_done == 0, "R4 no done before last byte", frame_done, 0);
        pec = force_pec ? pec_in : (e ^ (corrupt ? 8'h5A : 8'h00));
        push(pec);
        in_valid = 1'b0;
        chk(frame_done == 1, "R4 done after frame length", frame_done, 1);
        chk(crc_value == e, "R1 computed CRC", crc_value, e);
        chk(frame_ok == (pec == e), "R5 pass flag", frame_ok, pec == e);
        if (!gap) chk(cyc - t0 == L, "R10 one byte per cycle", cyc - t0, L);
        held_crc = crc_value; held_ok = frame_ok;
        in_valid = 1'b1; in_data = ~e;      // R7 junk after completion
        @(negedge clk);
        chk(frame_done == 0, "R9 done single cycle", frame_done, 0);
        @(negedge clk); @(negedge clk);
        in_valid = 1'b0;
        chk(crc_value == held_crc && frame_ok == held_ok && frame_done == 0,
            "R7 idle bytes ignored", crc_value, held_crc);
        exp_o = e;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame_done == 0 && frame_ok == 0 && crc_value == 0 && in_ready == 0,
            "R9 reset state", crc_value, 0);
        // R2 reference vector, literal expectation
        run_frame(1'b1, 1'b1, 0, 1'b0, 1'b1, 8'h9E, 1'b0, e);
        chk(crc_value == 8'h9E && frame_ok, "R2 repeated-start reference", crc_value, 8'h9E);
        // R3 reference vector, literal expectation
        run_frame(1'b0, 1'b1, 0, 1'b0, 1'b1, 8'hAF, 1'b0, e);
        chk(crc_value == 8'hAF && frame_ok, "R3 stop/start reference", crc_value, 8'hAF);
        // sweep over modes, lengths, patterns, gaps, good/bad check byte
        for (int m = 0; m < 2; m++)
            for (int l = 0; l < 2; l++)
                for (int p = 1; p < 5; p++)
                    for (int g = 0; g < 2; g++)
                        for (int c = 0; c < 2; c++)
                            run_frame(m[0], l[0], p, g[0], 1'b0, 8'h00, c[0], e);
        // R5 all 256 trailing values on a short frame: exactly one passes
        npass = 0;
        for (int v = 0; v < 256; v++) begin
            run_frame(1'b0, 1'b0, 3, 1'b0, 1'b1, 8'(v), 1'b0, e);
            if (frame_ok) npass++;
        end
        chk(npass == 1, "R5 single matching trailing byte", npass, 1);
        // R8 abort mid-payload, then a clean frame
        start_frame(1'b1, 1'b1);
        for (int i = 0; i < 6; i++) push(8'hA0 + 8'(i));
        in_valid = 1'b0;
        run_frame(1'b0, 1'b0, 2, 1'b0, 1'b0, 8'h00, 1'b0, e);
        chk(frame_ok == 1, "R8 abort mid-payload", frame_ok, 1);
        // R8 abort during header injection
        @(negedge clk); in_sof = 1'b1; hdr_rs = 1'b1; @(negedge clk); in_sof = 1'b0;
        run_frame(1'b1, 1'b0, 4, 1'b1, 1'b0, 8'h00, 1'b0, e);
        chk(frame_ok == 1 && crc_value == e, "R8 abort during header", crc_value, e);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule